// File: doc/BRIEF.md
# Frame Sync Phase Comparator Overlay

This block sits in the output pixel clock domain of a video scaler. It watches a frame-start pulse from the incoming video. That pulse has already been synchronised into this clock domain. On each rising edge of the pulse, the block records the output raster line and pixel where the edge landed. It then sorts the arrival into one of three classes: ahead of a target window of lines, behind it, or inside it. The result goes to a frequency-trim controller as a set of one-hot flags with a single-cycle valid strobe.

The same recorded position feeds a debug overlay on the RGB stream, which sits between colour conversion and the display encoder. The overlay paints a small upright bar at the recorded position, so the lock state can be seen live on the display. The bar is blue for an early arrival, red for a late one and green inside the window. Every other pixel passes through unchanged, in the same cycle.

Top module: `frame_phase_overlay`

## Requirements
- R1: When `vsyncSync` is high in a cycle and was low in the cycle before, the block captures `lineIdx` and `pixIdx` of that cycle. In the next cycle, `resValid` is high for exactly one cycle.
- R2: While `vsyncSync` stays high, it causes no further capture and no further `resValid`.
- R3: A captured line below TARGET_LINE-WINDOW sets `early`. Exactly one of `early`, `late` and `locked` is high once a result exists.
- R4: A captured line above TARGET_LINE+WINDOW sets `late`.
- R5: A captured line from TARGET_LINE-WINDOW to TARGET_LINE+WINDOW inclusive sets `locked`. The defaults are 8 and 2, so the window is lines 6 to 10.
- R6: The flags hold their value until the next result is issued.
- R7: After reset, `early`, `late`, `locked` and `resValid` are 0. Until the first capture, `rgbOut` equals `rgbIn`.
- R8: After a capture, a pixel is part of the bar if it meets both bounds below. Its pixel index lies from P-DASH_W/2 to P-DASH_W/2+DASH_W-1. Its line lies from L-DASH_H/2 to L-DASH_H/2+DASH_H-1. Here P and L are the captured pixel and line. With the defaults this is pixels P-2 to P+1 and lines L-8 to L+7.
- R9: A bar pixel shows 24'h0000FF when `early`, 24'hFF0000 when `late` and 24'h00FF00 when `locked`. The format is {R[23:16],G[15:8],B[7:0]}. Any pixel outside the bar takes `rgbIn` combinationally.
- R10: The bar is clipped at index 0 and does not wrap. With P=0, pixel 4094 is not part of the bar.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineIdx | input | 11 | Current output raster line |
| pixIdx | input | 12 | Current output raster pixel |
| vsyncSync | input | 1 | Input frame-start pulse, already in this clock domain |
| rgbIn | input | 24 | Incoming RGB pixel {R,G,B} |
| rgbOut | output | 24 | RGB pixel with bar overlay |
| resValid | output | 1 | One-cycle strobe per new result |
| early | output | 1 | Last arrival was before the window |
| late | output | 1 | Last arrival was after the window |
| locked | output | 1 | Last arrival was inside the window |

## Verification
The assertions assume that `vsyncSync` is a clean, glitch-free level that changes only at clock edges. This holds because the synchroniser ahead of the block registers it. They also assume reset is held for at least two cycles, so the two-deep history behind the edge check is defined. The bench drives every input on the falling clock edge and keeps the pulse low for at least one full cycle between arrivals. It holds the pulse high over several cycles only in the test for repeated edges.

// File: rtl/fpo_pkg.sv
package fpo_pkg;
  typedef struct packed {
    logic capture;
    logic markEnable;
  } fpo_strobe_t;

  localparam logic [23:0] COL_EARLY  = 24'h0000FF;
  localparam logic [23:0] COL_LATE   = 24'hFF0000;
  localparam logic [23:0] COL_LOCKED = 24'h00FF00;
endpackage

// File: rtl/fpo_ctrl.sv
module fpo_ctrl (
  input  logic                clk,
  input  logic                rstN,
  input  logic                vsyncSync,
  output fpo_pkg::fpo_strobe_t strb
);
  logic vsyncPrev;
  logic armed;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vsyncPrev <= 1'b0;
      armed     <= 1'b0;
    end else begin
      vsyncPrev <= vsyncSync;
      if (strb.capture) armed <= 1'b1;
    end
  end

  always_comb begin
    strb.capture    = vsyncSync & ~vsyncPrev;
    strb.markEnable = armed;
  end

  // a capture can never follow a capture in the next cycle (R2)
  assert_no_double_capture_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> !strb.capture);
endmodule

// File: rtl/fpo_datapath.sv
module fpo_datapath #(
  parameter int LINE_W      = 11,
  parameter int PIX_W       = 12,
  parameter int TARGET_LINE = 8,
  parameter int WINDOW      = 2,
  parameter int DASH_W      = 4,
  parameter int DASH_H      = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  fpo_pkg::fpo_strobe_t strb,
  input  logic [LINE_W-1:0]    lineIdx,
  input  logic [PIX_W-1:0]     pixIdx,
  input  logic [23:0]          rgbIn,
  input  logic                 vsyncSync,
  output logic [23:0]          rgbOut,
  output logic                 resValid,
  output logic                 early,
  output logic                 late,
  output logic                 locked
);
  import fpo_pkg::*;

  localparam int LO_EDGE = TARGET_LINE - WINDOW;
  localparam int HI_EDGE = TARGET_LINE + WINDOW;
  localparam int HALF_W  = DASH_W / 2;
  localparam int HALF_H  = DASH_H / 2;

  logic [LINE_W-1:0] latchLine;
  logic [PIX_W-1:0]  latchPix;
  int                curLine;
  int                dPix;
  int                dLine;
  logic              inDash;
  logic [23:0]       dashCol;

  assign curLine = int'(lineIdx);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latchLine <= '0;
      latchPix  <= '0;
      resValid  <= 1'b0;
      early     <= 1'b0;
      late      <= 1'b0;
      locked    <= 1'b0;
    end else begin
      resValid <= strb.capture;
      if (strb.capture) begin
        latchLine <= lineIdx;
        latchPix  <= pixIdx;
        early     <= (curLine < LO_EDGE);
        late      <= (curLine > HI_EDGE);
        locked    <= (curLine >= LO_EDGE) && (curLine <= HI_EDGE);
      end
    end
  end

  always_comb begin
    dPix   = int'(pixIdx) - int'(latchPix) + HALF_W;
    dLine  = curLine - int'(latchLine) + HALF_H;
    inDash = strb.markEnable && (dPix >= 0) && (dPix < DASH_W)
             && (dLine >= 0) && (dLine < DASH_H);
    if (early)     dashCol = COL_EARLY;
    else if (late) dashCol = COL_LATE;
    else           dashCol = COL_LOCKED;
    rgbOut = inDash ? dashCol : rgbIn;
  end

  assert_onehot_class_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({early, late, locked}));

  assert_result_after_edge_R1: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> ($past(vsyncSync) && !$past(vsyncSync, 2)));

  assert_flags_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !resValid |-> $stable({early, late, locked}));

  assert_single_strobe_R1: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid);

  assert_passthru_unarmed_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.markEnable |-> (rgbOut == rgbIn));
endmodule

// File: rtl/frame_phase_overlay.sv
module frame_phase_overlay #(
  parameter int LINE_W      = 11,
  parameter int PIX_W       = 12,
  parameter int TARGET_LINE = 8,
  parameter int WINDOW      = 2,
  parameter int DASH_W      = 4,
  parameter int DASH_H      = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LINE_W-1:0] lineIdx,
  input  logic [PIX_W-1:0]  pixIdx,
  input  logic              vsyncSync,
  input  logic [23:0]       rgbIn,
  output logic [23:0]       rgbOut,
  output logic              resValid,
  output logic              early,
  output logic              late,
  output logic              locked
);
  fpo_pkg::fpo_strobe_t strb;

  fpo_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .vsyncSync(vsyncSync), .strb(strb)
  );

  fpo_datapath #(
    .LINE_W(LINE_W), .PIX_W(PIX_W), .TARGET_LINE(TARGET_LINE),
    .WINDOW(WINDOW), .DASH_W(DASH_W), .DASH_H(DASH_H)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .lineIdx(lineIdx), .pixIdx(pixIdx),
    .rgbIn(rgbIn), .vsyncSync(vsyncSync), .rgbOut(rgbOut), .resValid(resValid),
    .early(early), .late(late), .locked(locked)
  );
endmodule

// File: tb/frame_phase_overlay_tb.sv
module frame_phase_overlay_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [10:0] lineIdx = '0;
  logic [11:0] pixIdx = '0;
  logic vsyncSync = 1'b0;
  logic [23:0] rgbIn;
  logic [23:0] rgbOut;
  logic resValid, early, late, locked;
  int applied = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  assign rgbIn = {pixIdx[7:0], lineIdx[7:0], 8'hA5};

  frame_phase_overlay dut_i (
    .clk(clk), .rstN(rstN), .lineIdx(lineIdx), .pixIdx(pixIdx),
    .vsyncSync(vsyncSync), .rgbIn(rgbIn), .rgbOut(rgbOut),
    .resValid(resValid), .early(early), .late(late), .locked(locked)
  );

  // {line, pix, early, late, locked}
  localparam logic [25:0] VEC [6] = '{
    {11'd3,   12'd100,  3'b100},
    {11'd6,   12'd200,  3'b001},
    {11'd10,  12'd640,  3'b001},
    {11'd11,  12'd50,   3'b010},
    {11'd700, 12'd1000, 3'b010},
    {11'd8,   12'd5,    3'b001}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] colOf(input logic [2:0] f);
    if (f[2]) return 24'h0000FF;
    if (f[1]) return 24'hFF0000;
    return 24'h00FF00;
  endfunction

  task automatic probe(input string req, input int ln, input int px, input logic [23:0] exp);
    @(negedge clk);
    lineIdx = 11'(ln);
    pixIdx  = 12'(px);
    #1;
    chk(req, {8'h0, rgbOut}, {8'h0, exp});
  endtask

  task automatic fire(input logic [10:0] ln, input logic [11:0] px, input logic [2:0] f);
    @(negedge clk);
    lineIdx = ln; pixIdx = px; vsyncSync = 1'b1;
    @(negedge clk);
    chk("R1 valid", {31'h0, resValid}, 32'h1);
    chk("R3/R4/R5 class", {29'h0, early, late, locked}, {29'h0, f});
    vsyncSync = 1'b0;
    @(negedge clk);
    chk("R1 single strobe", {31'h0, resValid}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R7 reset flags", {28'h0, resValid, early, late, locked}, 32'h0);
    probe("R7 passthru before capture", 8, 100, {8'd100, 8'd8, 8'hA5});
    rstN = 1'b1;
    probe("R7 passthru unarmed", 3, 2, {8'd2, 8'd3, 8'hA5});
    foreach (VEC[i]) begin
      logic [10:0] ln;
      logic [11:0] px;
      logic [2:0]  f;
      {ln, px, f} = VEC[i];
      fire(ln, px, f);
      probe("R9 centre colour", int'(ln), int'(px), colOf(f));
      probe("R8 left edge", int'(ln) + 7, int'(px) - 2, colOf(f));
      probe("R9 right outside", int'(ln), int'(px) + 2,
            {8'(int'(px) + 2), ln[7:0], 8'hA5});
      probe("R8 below outside", int'(ln) + 8, int'(px),
            {px[7:0], 8'(int'(ln) + 8), 8'hA5});
      chk("R6 flags held", {29'h0, early, late, locked}, {29'h0, f});
    end
    // R2: held high, no re-capture
    @(negedge clk);
    lineIdx = 11'd8; pixIdx = 12'd300; vsyncSync = 1'b1;
    @(negedge clk);
    chk("R2 first edge valid", {31'h0, resValid}, 32'h1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      lineIdx = 11'd40;
      #1;
      chk("R2 no restrobe", {31'h0, resValid}, 32'h0);
    end
    @(negedge clk);
    chk("R2 class unchanged", {29'h0, early, late, locked}, 32'h1);
    vsyncSync = 1'b0;
    // R10 clip at zero
    fire(11'd0, 12'd0, 3'b100);
    probe("R10 no wrap pix 4094", 0, 4094, {8'hFE, 8'd0, 8'hA5});
    probe("R10 pixel 0 marked", 0, 0, 24'h0000FF);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end
endmodule